// File: doc/BRIEF.md
# Periodic Battery Health Monitor

This block watches a backup battery on behalf of a supply supervisor. While the main supply is reported valid, it counts a slow time tick and, at each interval, turns on a test load on the battery for a short window. On the last clock of that window it samples a synchronised "battery below threshold" comparator flag. A failing sample raises a sticky warning that drives an open-drain pull-down.

A periodic test that passes leaves the warning as it is. Every return of the supply forces a fresh test, and that power-up test can clear the warning when it passes. A module-replaced strobe also clears the warning. When the supply is lost, all counting stops and the load is removed at once. A test that is under way is dropped and the warning is left untouched. Both periods are parameters counted in ticks. The interval default is 86400 one-second ticks and the window default is one tick.

Top module: `batt_health_mon`

## Requirements
- R1: After reset, `load_en_o` and `warn_en_o` are both 0, and no test starts until `supply_ok_i` is seen high.
- R2: On the first clock edge at which `supply_ok_i` is high after it was low (or after reset), the block starts a power-up test, and `load_en_o` is 1 from the following cycle.
- R3: A test keeps `load_en_o` at 1 for exactly `WINDOW_TICKS` ticks. The load falls after the clock edge on which the last of those ticks arrives.
- R4: The comparator flag passes through `SYNC_STAGES` flip-flops and is sampled on the last clock of the window. A sample of 1 (battery low) sets `warn_en_o` to 1 at that edge.
- R5: After a test ends, the block counts `INTERVAL_TICKS` ticks with the load off. On the clock edge of the last of those ticks it starts a periodic test.
- R6: A periodic test whose sample is 0 does not clear an active warning.
- R7: A power-up test whose sample is 0 clears the warning.
- R8: While `supply_ok_i` is 0, `load_en_o` is 0 in the same cycle, without waiting for a clock. Tick counting is suspended, and `warn_en_o` holds its value except under R9.
- R9: A 1 on `replaced_i` at a clock edge clears `warn_en_o` at that edge. It takes priority over a failing sample in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | One-cycle pulse of the slow time base |
| supply_ok_i | input | 1 | Main supply valid, after the supervisor's recovery interval |
| batt_low_i | input | 1 | Asynchronous comparator output, 1 = battery under threshold |
| replaced_i | input | 1 | One-cycle strobe: battery module was replaced |
| load_en_o | output | 1 | Connects the test load to the battery |
| warn_en_o | output | 1 | Enables the open-drain warning pull-down (1 = warning) |

## Verification
A wrong window or interval count shows up at `load_en_o` as a pulse that is too short, too long or off schedule. This is visible within one interval plus one window of ticks. A warning update with the wrong rule (sticky, power-up clear or replace priority) shows at `warn_en_o` on the edge after the sampling clock. A wrong state after a supply drop shows either as a load that stays on in the same cycle, or as a missing power-up test on the next cycle the supply is back. The bench compares both outputs in every cycle against a tick-level model of these rules, so any such divergence is reported in the cycle it first appears.

// File: rtl/bhm_pkg.sv
package bhm_pkg;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_TEST = 2'd1,
    ST_WAIT = 2'd2
  } bhm_state_e;

  // Counter width able to hold values 0 .. limit-1
  function automatic int cnt_width(input int limit);
    return (limit > 2) ? $clog2(limit) : 1;
  endfunction

  // Warning value after a clock edge
  function automatic logic warn_next(input logic cur,
                                     input logic sample_ev,
                                     input logic low,
                                     input logic pu_test,
                                     input logic replaced);
    if (replaced)       return 1'b0;
    if (!sample_ev)     return cur;
    if (low)            return 1'b1;
    if (pu_test)        return 1'b0;
    return cur;
  endfunction

endpackage

// File: rtl/bhm_sync.sv
module bhm_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/bhm_tick_cnt.sv
module bhm_tick_cnt
  import bhm_pkg::*;
#(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic run_i,
  input  logic tick_i,
  output logic last_o
);
  localparam int W = cnt_width(LIMIT);
  localparam logic [W-1:0] TOP = W'(LIMIT - 1);

  logic [W-1:0] cnt_q;

  assign last_o = run_i && tick_i && (cnt_q == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (run_i && tick_i)   cnt_q <= (cnt_q == TOP) ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/bhm_ctrl.sv
module bhm_ctrl
  import bhm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_ok_i,
  input  logic       win_last_i,
  input  logic       int_last_i,
  output bhm_state_e state_o,
  output logic       pu_test_o
);
  bhm_state_e state_q, state_d;
  logic       pu_q, pu_d;

  always_comb begin
    state_d = state_q;
    pu_d    = pu_q;
    if (!supply_ok_i) begin
      state_d = ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF:  begin state_d = ST_TEST; pu_d = 1'b1; end
        ST_TEST: if (win_last_i) state_d = ST_WAIT;
        ST_WAIT: if (int_last_i) begin state_d = ST_TEST; pu_d = 1'b0; end
        default: state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      pu_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      pu_q    <= pu_d;
    end
  end

  assign state_o   = state_q;
  assign pu_test_o = pu_q;
endmodule

// File: rtl/batt_health_mon.sv
module batt_health_mon
  import bhm_pkg::*;
#(
  parameter int INTERVAL_TICKS = 86400,
  parameter int WINDOW_TICKS   = 1,
  parameter int SYNC_STAGES    = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic supply_ok_i,
  input  logic batt_low_i,
  input  logic replaced_i,
  output logic load_en_o,
  output logic warn_en_o
);
  bhm_state_e state;
  logic       pu_test;
  logic       in_test, in_wait;
  logic       win_done, int_done;
  logic       low_sync;
  logic       warn_q;

  assign in_test = (state == ST_TEST);
  assign in_wait = (state == ST_WAIT);

  bhm_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(batt_low_i), .q_o(low_sync)
  );

  bhm_tick_cnt #(.LIMIT(WINDOW_TICKS)) u_win_cnt (
    .clk(clk), .rst_n(rst_n), .clr_i(!in_test),
    .run_i(in_test && supply_ok_i), .tick_i(tick_i), .last_o(win_done)
  );

  bhm_tick_cnt #(.LIMIT(INTERVAL_TICKS)) u_int_cnt (
    .clk(clk), .rst_n(rst_n), .clr_i(!in_wait),
    .run_i(in_wait && supply_ok_i), .tick_i(tick_i), .last_o(int_done)
  );

  bhm_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .supply_ok_i(supply_ok_i),
    .win_last_i(win_done), .int_last_i(int_done),
    .state_o(state), .pu_test_o(pu_test)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) warn_q <= 1'b0;
    else        warn_q <= warn_next(warn_q, win_done, low_sync, pu_test, replaced_i);
  end

  assign load_en_o = in_test && supply_ok_i;
  assign warn_en_o = warn_q;
endmodule

// File: rtl/bhm_checker.sv
module bhm_checker (
  input logic clk,
  input logic rst_n,
  input logic supply_ok_i,
  input logic replaced_i,
  input logic load_en_o,
  input logic warn_en_o,
  input logic win_done,
  input logic pu_test
);
  // R8: load never on without supply
  a_r8_load_needs_supply: assert property (@(posedge clk) disable iff (!rst_n)
    load_en_o |-> supply_ok_i);

  // R2: supply return starts a test on the next cycle
  a_r2_powerup_test: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(supply_ok_i) |=> (load_en_o || !supply_ok_i));

  // R3: the load is off after the window's last tick
  a_r3_load_drops: assert property (@(posedge clk) disable iff (!rst_n)
    win_done |=> !load_en_o);

  // R4: a warning only rises after a sample
  a_r4_rise_on_sample: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(warn_en_o) |-> $past(win_done));

  // R6, R7: a warning only falls on replace or a power-up sample
  a_r7_fall_rule: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(warn_en_o) |-> $past(replaced_i || (win_done && pu_test)));

  // R9: replace clears the warning
  a_r9_replace_clears: assert property (@(posedge clk) disable iff (!rst_n)
    replaced_i |=> !warn_en_o);
endmodule

bind batt_health_mon bhm_checker u_bhm_checker (
  .clk(clk), .rst_n(rst_n), .supply_ok_i(supply_ok_i), .replaced_i(replaced_i),
  .load_en_o(load_en_o), .warn_en_o(warn_en_o),
  .win_done(win_done), .pu_test(pu_test)
);

// File: tb/batt_health_mon_tb.sv
module batt_health_mon_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int INT_T  = 12;
  localparam int WIN_T  = 3;
  localparam int SYNC_N = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, sup = 1'b0, low = 1'b0, repl = 1'b0;
  logic load_en, warn_en;

  int n_checks = 0;
  int n_errors = 0;
  string cur_tag = "R1";
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  batt_health_mon #(.INTERVAL_TICKS(INT_T), .WINDOW_TICKS(WIN_T), .SYNC_STAGES(SYNC_N)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .supply_ok_i(sup),
    .batt_low_i(low), .replaced_i(repl), .load_en_o(load_en), .warn_en_o(warn_en)
  );

  // Reference model of the requirements: phase 0 off, 1 testing, 2 waiting
  int   m_phase = 0;
  int   m_ticks = 0;
  bit   m_pu = 0;
  bit   m_warn = 0;
  bit   m_low_pipe [SYNC_N];

  function automatic bit exp_load(int phase, bit s);
    return (phase == 1) && s;
  endfunction

  function automatic bit exp_warn(bit w, bit sampled, bit lowv, bit pu, bit r);
    if (r) return 1'b0;
    if (sampled && lowv) return 1'b1;
    if (sampled && pu) return 1'b0;
    return w;
  endfunction

  initial foreach (m_low_pipe[i]) m_low_pipe[i] = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_ticks = 0; m_pu = 0; m_warn = 0;
      foreach (m_low_pipe[i]) m_low_pipe[i] = 1'b0;
    end else begin
      bit sampled;
      bit lowv;
      lowv = m_low_pipe[SYNC_N-1];
      sampled = sup && (m_phase == 1) && tick && (m_ticks == WIN_T-1);
      m_warn = exp_warn(m_warn, sampled, lowv, m_pu, repl);
      if (!sup) begin
        m_phase = 0; m_ticks = 0;
      end else if (m_phase == 0) begin
        m_phase = 1; m_ticks = 0; m_pu = 1;
      end else if (m_phase == 1) begin
        if (sampled) begin m_phase = 2; m_ticks = 0; end
        else if (tick) m_ticks++;
      end else begin
        if (tick && m_ticks == INT_T-1) begin m_phase = 1; m_ticks = 0; m_pu = 0; end
        else if (tick) m_ticks++;
      end
      for (int i = SYNC_N-1; i > 0; i--) m_low_pipe[i] = m_low_pipe[i-1];
      m_low_pipe[0] = low;
    end
  end

  task automatic chk(string tag, string what, logic act, logic exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Continuous comparison mid-cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(cur_tag, "load_en_o vs model", load_en, exp_load(m_phase, sup));
      chk(cur_tag, "warn_en_o vs model", warn_en, m_warn);
    end
  end

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_errors++; n_checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    int hi_cnt;
    void'($urandom(32'd4242));
    step(3);
    #(CLK_PERIOD/2 - 1);
    chk("R1", "load after reset", load_en, 1'b0);
    chk("R1", "warn after reset", warn_en, 1'b0);
    @(posedge clk); #1;
    rst_n = 1'b1;
    step(3);
    chk("R1", "no test without supply", load_en, 1'b0);

    // R2, R3, R4: power-up test with a low battery, tick every cycle
    cur_tag = "R4"; low = 1'b1; tick = 1'b1;
    step(3);
    sup = 1'b1;
    step(1);
    chk("R2", "load the cycle after supply", load_en, 1'b1);
    hi_cnt = 1;
    while (load_en && hi_cnt < 20) begin step(1); if (load_en) hi_cnt++; end
    n_checks++;
    if (hi_cnt != WIN_T) begin
      n_errors++;
      $display("FAIL R3 window length: actual=%0d expected=%0d", hi_cnt, WIN_T);
    end
    chk("R4", "warn after failing sample", warn_en, 1'b1);

    // R5, R6: periodic test passing keeps warning
    cur_tag = "R6"; low = 1'b0;
    hi_cnt = 0;
    while (!load_en && hi_cnt < 40) begin step(1); hi_cnt++; end
    n_checks++;
    if (hi_cnt != INT_T) begin
      n_errors++;
      $display("FAIL R5 interval length: actual=%0d expected=%0d", hi_cnt, INT_T);
    end
    step(WIN_T + 2);
    chk("R6", "warn sticky over periodic pass", warn_en, 1'b1);

    // R8: drop supply in the middle of a test
    cur_tag = "R8";
    while (!load_en) step(1);
    step(1);
    sup = 1'b0;
    #2;
    chk("R8", "load removed at once", load_en, 1'b0);
    step(5);
    chk("R8", "warn kept over power loss", warn_en, 1'b1);

    // R7: power-up retest passes and clears
    cur_tag = "R7";
    sup = 1'b1;
    step(WIN_T + 3);
    chk("R7", "warn cleared by power-up pass", warn_en, 1'b0);

    // R9: set again by a low power-up test, then replace
    cur_tag = "R9"; low = 1'b1; sup = 1'b0;
    step(2);
    sup = 1'b1;
    step(WIN_T + 4);
    chk("R4", "warn set again", warn_en, 1'b1);
    repl = 1'b1; step(1); repl = 1'b0;
    chk("R9", "warn cleared by replace", warn_en, 1'b0);

    // Constrained random phase
    cur_tag = "R5";
    for (int c = 0; c < 6000; c++) begin
      tick = ($urandom % 3) == 0;
      if (sup && ($urandom % 250) == 0) sup = 1'b0;
      else if (!sup && ($urandom % 6) == 0) sup = 1'b1;
      if (($urandom % 40) == 0) low = ~low;
      repl = ($urandom % 300) == 0;
      step(1);
    end
    repl = 1'b0; tick = 1'b0;
    step(2);
    finish_run();
  end
endmodule